// File: doc/BRIEF.md
# Preloaded PWM Timer with Start Synchronisation

The block is an up-counting timer that produces one PWM output. A small write port sets a control word, the period (the counter's top value) and the compare (duty) value. Period and compare each have their own preload switch. With preload on, a write goes to a shadow register and reaches the active register only at the next update event. With preload off, the write reaches the active register on the same edge. The output polarity can be chosen. The counter width is the parameter `CNT_W`, meant for 16 or 32.

Two instances can run phase-locked. The start pulse of one instance (the master) drives the trigger input of another (the slave). The slave has its enable bit set and is in slave mode. It waits for the rising edge of that pulse and then starts counting on the same cycle as the master. When both have the same period, their update strobes coincide on every wrap.

Write map: address 0 is the control word, address 1 is the period, address 2 is the compare value. Address 3 is ignored. Control bits: bit 0 enable, bit 1 period preload, bit 2 compare preload, bit 3 active-low output, bit 4 slave mode, bit 5 update request (a one-shot, not stored).

Top module: `pwm_sync_timer`

## Requirements
- R1: While running, the counter steps by one per cycle from 0. `upd_o` is high in the cycle where the counter equals the active period, and the counter is 0 on the next cycle. The interval between strobes is period+1 cycles.
- R2: With period preload on (control bit 1), a period write leaves the active period unchanged until the next update event. From that event on, the new period applies.
- R3: With period preload off, a period write takes effect on the next edge. If the counter is already above the new value, it does not match. It runs on to all-ones, rolls over to 0 without an update strobe, and strobes when it next equals the new period.
- R4: With compare preload on (control bit 2), a compare write does not change the output until the next update event. With it off, the new compare value drives the output from the next cycle.
- R5: While running, the output is active in cycles where counter < active compare. It is inactive otherwise. Bit 3 = 1 makes the active level low. Clearing the enable bit stops the counter and returns it to 0 within two cycles.
- R6: An active period of 0 holds the counter at 0, keeps the output inactive and strobes `upd_o` every running cycle.
- R7: A control write with bit 5 set raises `upd_o` in the next cycle. That event copies both shadow registers into the active registers and puts the counter at 0 on the following edge.
- R8: `trig_o` is high for exactly one cycle, the cycle after a control write that sets the enable bit while it was clear.
- R9: In slave mode (bit 4) with enable set, the counter stays at 0 until a rising edge on `trig_i`. When `trig_i` is a master's `trig_o`, master and slave show equal counter values and equal `upd_o` on every following cycle.
- R10: During and after reset the outputs are low and the counter is 0. The active compare resets to 0, so enabling without a compare write keeps the output inactive. The period resets to all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 compare |
| wr_data | input | CNT_W | Write data |
| trig_i | input | 1 | Start trigger, used in slave mode |
| pwm_o | output | 1 | PWM output |
| trig_o | output | 1 | One-cycle start pulse for a slave |
| upd_o | output | 1 | Update event strobe |
| cnt_o | output | CNT_W | Current counter value |

## Verification
A write is visible in the registers after the edge that samples it. A master starts counting two edges after its enable write: the first edge records the run state, the second increments the counter. `upd_o` and `pwm_o` are decoded from registered state, so they follow the counter within the same cycle. An update request shows on `upd_o` in the cycle right after its write. The bench drives and samples only on falling edges. It counts those edges from each write and compares against these latencies, for example 65476 edges from the late period write to the delayed strobe.

// File: rtl/tim_pkg.sv
`timescale 1ns/1ps
package tim_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_PER  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CMP  = 2'd2;
    localparam int UG_BIT = 5;

    // packed: first field is the MSB, so en lands on bit 0
    typedef struct packed {
        logic slave;
        logic pol_low;
        logic cmp_pre;
        logic per_pre;
        logic en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tim_regs.sv
`timescale 1ns/1ps
module tim_regs
    import tim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              upd_evt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  per_act,
    output logic [CNT_W-1:0]  cmp_act,
    output logic              ug,
    output logic              trig_pulse
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] per_sh;
        logic [CNT_W-1:0] per_act;
        logic [CNT_W-1:0] cmp_sh;
        logic [CNT_W-1:0] cmp_act;
        logic             ug;
        logic             trig;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic sel_ctrl, sel_per, sel_cmp;

    always_comb begin
        sel_ctrl = wr_en && (wr_addr == A_CTRL);
        sel_per  = wr_en && (wr_addr == A_PER);
        sel_cmp  = wr_en && (wr_addr == A_CMP);

        st_d      = st_q;
        st_d.ug   = 1'b0;
        st_d.trig = 1'b0;

        // update event: shadows move into the active registers
        if (upd_evt) begin
            st_d.per_act = st_q.per_sh;
            st_d.cmp_act = st_q.cmp_sh;
        end

        if (sel_ctrl) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0]);
            st_d.ug   = wr_data[UG_BIT];
            st_d.trig = wr_data[0] && !st_q.ctrl.en;
        end

        if (sel_per) begin
            st_d.per_sh = wr_data;
            if (!st_q.ctrl.per_pre) st_d.per_act = wr_data;
        end

        if (sel_cmp) begin
            st_d.cmp_sh = wr_data;
            if (!st_q.ctrl.cmp_pre) st_d.cmp_act = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl    <= '0;
            st_q.per_sh  <= '1;
            st_q.per_act <= '1;
            st_q.cmp_sh  <= '0;
            st_q.cmp_act <= '0;
            st_q.ug      <= 1'b0;
            st_q.trig    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl       = st_q.ctrl;
    assign per_act    = st_q.per_act;
    assign cmp_act    = st_q.cmp_act;
    assign ug         = st_q.ug;
    assign trig_pulse = st_q.trig;
endmodule

// File: rtl/tim_counter.sv
`timescale 1ns/1ps
module tim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             slave,
    input  logic             ug,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             upd_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             trig_prev;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic trig_rise, per_zero, at_top;

    always_comb begin
        trig_rise = trig_i && !st_q.trig_prev;
        per_zero  = (per_act == '0);
        // equality only: a counter past the top value does not match
        at_top    = (st_q.cnt == per_act);
        upd_evt   = ug || (st_q.run && (at_top || per_zero));

        st_d           = st_q;
        st_d.trig_prev = trig_i;

        if (!en)             st_d.run = 1'b0;
        else if (!slave)     st_d.run = 1'b1;
        else if (trig_rise)  st_d.run = 1'b1;

        if (upd_evt || !st_q.run) st_d.cnt = '0;
        else                      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign run = st_q.run;
endmodule

// File: rtl/tim_outstage.sv
`timescale 1ns/1ps
module tim_outstage #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic             pol_low,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_act,
    input  logic [CNT_W-1:0] per_act,
    output logic             pwm
);
    logic active;

    always_comb begin
        active = run && (per_act != '0) && (cnt < cmp_act);
        pwm    = active ^ pol_low;
    end
endmodule

// File: rtl/pwm_sync_timer.sv
`timescale 1ns/1ps
module pwm_sync_timer
    import tim_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [CNT_W-1:0]     wr_data,
    input  logic                 trig_i,
    output logic                 pwm_o,
    output logic                 trig_o,
    output logic                 upd_o,
    output logic [CNT_W-1:0]     cnt_o
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] per_act;
    logic [CNT_W-1:0] cmp_act;
    logic [CNT_W-1:0] cnt;
    logic             ug;
    logic             run;
    logic             upd_evt;

    tim_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .upd_evt    (upd_evt),
        .ctrl       (ctrl),
        .per_act    (per_act),
        .cmp_act    (cmp_act),
        .ug         (ug),
        .trig_pulse (trig_o)
    );

    tim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (ctrl.en),
        .slave   (ctrl.slave),
        .ug      (ug),
        .trig_i  (trig_i),
        .per_act (per_act),
        .cnt     (cnt),
        .run     (run),
        .upd_evt (upd_evt)
    );

    tim_outstage #(.CNT_W(CNT_W)) u_out (
        .run     (run),
        .pol_low (ctrl.pol_low),
        .cnt     (cnt),
        .cmp_act (cmp_act),
        .per_act (per_act),
        .pwm     (pwm_o)
    );

    assign upd_o = upd_evt;
    assign cnt_o = cnt;
endmodule

// File: rtl/pwm_sync_timer_chk.sv
`timescale 1ns/1ps
module pwm_sync_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ug,
    input logic             per_pre,
    input logic             cmp_pre,
    input logic [CNT_W-1:0] per_act,
    input logic [CNT_W-1:0] cmp_act,
    input logic [CNT_W-1:0] cnt_o,
    input logic             upd_o,
    input logic             trig_o,
    input logic             pwm_o,
    input logic             pol_low
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |=> (cnt_o == '0)); // R1
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !upd_o) |=> (cnt_o == $past(cnt_o) + ONE)); // R3
    AST_PER_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (per_pre && !upd_o) |=> $stable(per_act)); // R2
    AST_CMP_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_pre && !upd_o) |=> $stable(cmp_act)); // R4
    AST_STOPPED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_o == '0)); // R5
    AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_act == '0) |-> (upd_o && pwm_o == pol_low)); // R6
    AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt_o == '0)); // R7
    AST_TRIG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o); // R8
endmodule

bind pwm_sync_timer pwm_sync_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ug      (ug),
    .per_pre (ctrl.per_pre),
    .cmp_pre (ctrl.cmp_pre),
    .per_act (per_act),
    .cmp_act (cmp_act),
    .cnt_o   (cnt_o),
    .upd_o   (upd_o),
    .trig_o  (trig_o),
    .pwm_o   (pwm_o),
    .pol_low (ctrl.pol_low)
);

// File: tb/pwm_sync_timer_test.sv
`timescale 1ns/1ps
module pwm_sync_timer_test;
    localparam int W = 16;
    localparam logic [1:0] AC = 2'd0, AP = 2'd1, AM = 2'd2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_we = 1'b0, s_we = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic m_pwm, m_trig, m_upd, s_pwm, s_trig, s_upd;
    logic [W-1:0] m_cnt, s_cnt;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    pwm_sync_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(m_we), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_i(1'b0), .pwm_o(m_pwm), .trig_o(m_trig), .upd_o(m_upd), .cnt_o(m_cnt));

    pwm_sync_timer #(.CNT_W(W)) slv (
        .clk(clk), .rst_n(rst_n), .wr_en(s_we), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_i(m_trig), .pwm_o(s_pwm), .trig_o(s_trig), .upd_o(s_upd), .cnt_o(s_cnt));

    typedef struct packed {
        logic [15:0] per;
        logic [15:0] cmp;
        logic        pol;
        logic [15:0] high;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd9,  16'd3,  1'b0, 16'd3},
        '{16'd9,  16'd0,  1'b0, 16'd0},
        '{16'd9,  16'd10, 1'b0, 16'd10},
        '{16'd4,  16'd2,  1'b1, 16'd3},
        '{16'd15, 16'd8,  1'b0, 16'd8},
        '{16'd1,  16'd1,  1'b1, 16'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called on a falling edge; returns on the falling edge after the write edge
    task automatic wr(input bit to_slv, input logic [1:0] a, input logic [W-1:0] d);
        wr_addr = a;
        wr_data = d;
        if (to_slv) s_we = 1'b1; else m_we = 1'b1;
        @(negedge clk);
        m_we = 1'b0;
        s_we = 1'b0;
    endtask

    task automatic wait_upd(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!m_upd);
    endtask

    task automatic wait_cnt(input logic [W-1:0] v);
        while (m_cnt != v) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int k, hi, mism, supd;
        repeat (3) @(negedge clk);
        chk("R10 pwm in reset", {31'd0, m_pwm}, 0);
        chk("R10 upd in reset", {31'd0, m_upd}, 0);
        chk("R10 trig in reset", {31'd0, m_trig}, 0);
        chk("R10 cnt in reset", {16'd0, m_cnt}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 cnt after reset", {16'd0, m_cnt}, 0);

        // enable with reset values: all-ones period, compare 0
        wr(0, AC, 16'h0001);
        chk("R8 trig pulse", {31'd0, m_trig}, 1);
        @(negedge clk);
        chk("R8 trig single", {31'd0, m_trig}, 0);
        hi = 0;
        for (int i = 2; i <= 20; i++) begin
            @(negedge clk);
            if (m_pwm) hi++;
        end
        chk("R1 count after enable", {16'd0, m_cnt}, 19);
        chk("R10 output inactive with reset compare", hi, 0);
        chk("R8 slave ignores trigger when disabled", {16'd0, s_cnt}, 0);
        wr(0, AC, 16'h0000);
        repeat (2) @(negedge clk);
        chk("R5 disable clears counter", {16'd0, m_cnt}, 0);

        // vector table, direct (unbuffered) updates
        foreach (VECS[v]) begin
            wr(0, AC, 16'h0000);
            wr(0, AP, VECS[v].per);
            wr(0, AM, VECS[v].cmp);
            wr(0, AC, 16'h0001 | (16'(VECS[v].pol) << 3));
            wait_upd(k);
            hi = 0;
            for (int i = 0; i <= int'(VECS[v].per); i++) begin
                @(negedge clk);
                if (m_pwm) hi++;
            end
            chk("R1 strobe after period+1 cycles", {31'd0, m_upd}, 1);
            chk("R5 high cycles per period", hi, 32'(VECS[v].high));
        end

        // compare preload on
        wr(0, AC, 16'h0000);
        wr(0, AP, 16'd9);
        wr(0, AM, 16'd3);
        wr(0, AC, 16'h0005);
        wait_upd(k);
        wait_cnt(16'd5);
        wr(0, AM, 16'd7);
        chk("R4 preloaded compare held", {31'd0, m_pwm}, 0);
        wait_upd(k);
        hi = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (m_pwm) hi++;
        end
        chk("R4 preloaded compare applied at update", hi, 7);
        // compare preload off
        wr(0, AC, 16'h0001);
        wait_cnt(16'd5);
        wr(0, AM, 16'd2);
        chk("R4 direct compare immediate", {31'd0, m_pwm}, 0);

        // unbuffered period shrink past the counter: long cycle
        wr(0, AC, 16'h0000);
        wr(0, AP, 16'd99);
        wr(0, AM, 16'd50);
        wr(0, AC, 16'h0001);
        wait_upd(k);
        wait_cnt(16'd80);
        wr(0, AP, 16'd20);
        wait_upd(k);
        chk("R3 long cycle after late write", k, 65475);
        chk("R3 strobe at new period", {16'd0, m_cnt}, 20);
        wait_upd(k);
        chk("R3 next interval", k, 21);

        // buffered period shrink: no long cycle
        wr(0, AC, 16'h0000);
        wr(0, AP, 16'd99);
        wr(0, AC, 16'h0003);
        wait_upd(k);
        wait_cnt(16'd80);
        wr(0, AP, 16'd20);
        wait_upd(k);
        chk("R2 old period finishes", k, 18);
        chk("R2 strobe at old period", {16'd0, m_cnt}, 99);
        wait_upd(k);
        chk("R2 new period after update", k, 21);

        // software update request
        wr(0, AP, 16'd30);
        wr(0, AC, 16'h0023);
        chk("R7 strobe after request", {31'd0, m_upd}, 1);
        wait_upd(k);
        chk("R7 counter restarted with shadow period", k, 31);

        // zero period
        wr(0, AC, 16'h0001);
        wr(0, AM, 16'd3);
        wr(0, AP, 16'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 counter held", {16'd0, m_cnt}, 0);
            chk("R6 strobe each cycle", {31'd0, m_upd}, 1);
            chk("R6 output inactive", {31'd0, m_pwm}, 0);
        end

        // master / slave start
        wr(0, AC, 16'h0000);
        wr(1, AC, 16'h0000);
        wr(0, AP, 16'd9);
        wr(1, AP, 16'd9);
        wr(0, AM, 16'd4);
        wr(1, AM, 16'd4);
        wr(1, AC, 16'h0011);
        repeat (5) @(negedge clk);
        chk("R9 armed slave waits", {16'd0, s_cnt}, 0);
        wr(0, AC, 16'h0001);
        mism = 0;
        supd = 0;
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            if (m_cnt != s_cnt || m_upd != s_upd || m_pwm != s_pwm) mism++;
            if (s_upd) supd++;
        end
        chk("R9 lockstep mismatches", mism, 0);
        chk("R9 slave strobes", supd, 4);
        chk("R9 slave counter", {16'd0, s_cnt}, 9);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule